// File: doc/BRIEF.md
# Exchange and NOP Issue Classifier

This block sits in a simplified instruction issue stage. Each incoming decoded instruction arrives on a valid/ready stream as up to two opcode bytes. With it come a mode flag for the 64-bit or legacy execution mode, an operand-size flag, and the source and destination register indices. The block checks the instruction against a busy-register scoreboard, decides whether it can issue, and reports three things: a class, the number of issue cycles it occupies, and whether its result must be zero-extended to 64 bits. It also reports whether the issued instruction claims its destination in the scoreboard.

The single-byte code 0x90 is the only special case. It issues in one cycle, ignores the scoreboard and claims no register, so it never waits on an earlier producer and never holds up a later reader. Register-to-register exchanges take three issue cycles. Multi-byte forms that happen to do nothing, such as the two-byte-escape NOP or an address computation onto itself, are handled like any other instruction and keep their register hazards. In 64-bit mode, a 32-bit self-exchange of the accumulator has to be written as 0x87 0xC0. It is an exchange whose result is zero-extended, as is every 32-bit register result in that mode.

Top module: `nop_issue_classifier`

## Requirements
- R1: Byte 0x90 is classified as a no-operation (`iss_cls` = 1) in both modes and reports 1 issue cycle.
- R2: Byte 0x91..0x97, or byte 0x87 followed by a byte whose bits [7:6] are 11, is classified as an exchange (`iss_cls` = 2) and reports 3 cycles. After it is accepted, `in_ready` stays low for the next two cycles and returns in the third.
- R3: A 0x90 instruction is accepted even when every scoreboard bit is set. It reports `iss_mark` = 0 and `iss_zext` = 0.
- R4: Any instruction other than 0x90 is held with `in_ready` low while the busy bit of its source or destination register is set. It is accepted on the first edge after that bit clears. This applies to 0x0F 0x1F and to 0x8D as well.
- R5: Any instruction that is neither 0x90 nor an exchange is classified as other (`iss_cls` = 0), reports 1 cycle, and leaves `in_ready` high in the following cycle.
- R6: `iss_zext` is 1 exactly when the accepted instruction was issued in 64-bit mode (`mode64` = 1) with 32-bit operands (`op32` = 1) and writes a register. This includes 0x87 0xC0. In legacy mode it is always 0.
- R7: An accepted instruction that writes a register reports `iss_mark` = 1 and `iss_dst` equal to its destination index. The 0x90 and 0x0F 0x1F forms report `iss_mark` = 0.
- R8: `iss_valid` is high for exactly one cycle after each accepted transfer and is low otherwise, including while `in_valid` is low.
- R9: After reset, `in_ready` is 1 and `iss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte (register-form byte or escape tail) |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy 16/32-bit mode |
| op32 | input | 1 | Instruction uses 32-bit operands |
| src_reg | input | 4 | Source register index |
| dst_reg | input | 4 | Destination register index |
| busy_mask | input | 16 | Scoreboard, one busy bit per register |
| iss_valid | output | 1 | One-cycle pulse per accepted instruction |
| iss_cls | output | 2 | 0 other, 1 no-operation, 2 exchange |
| iss_cycles | output | 2 | Issue cycles the instruction occupies |
| iss_zext | output | 1 | Result is to be zero-extended to 64 bits |
| iss_mark | output | 1 | Destination is to be marked busy |
| iss_dst | output | 4 | Destination index to mark |

## Verification
A wrong occupancy count shows up at `in_ready` within two cycles of an exchange being accepted: the port either reopens one cycle early or stays closed for one cycle too many. A misclassified opcode shows up one cycle after acceptance, as a wrong `iss_cls`, a wrong cycle count or a spurious `iss_mark`. A hazard check that ignores the 0x90 exception, or that wrongly extends it to the multi-byte forms, shows up at once as `in_ready` low or high while the scoreboard bits are forced.

// File: rtl/nop_issue_classifier.sv
module nop_issue_classifier #(
  parameter int NREG        = 16,
  parameter int XCHG_CYCLES = 3,
  parameter int BASE_CYCLES = 1,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(XCHG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    op_b0,
  input  logic [7:0]    op_b1,
  input  logic          mode64,
  input  logic          op32,
  input  logic [RW-1:0] src_reg,
  input  logic [RW-1:0] dst_reg,
  input  logic [NREG-1:0] busy_mask,
  output logic          iss_valid,
  output logic [1:0]    iss_cls,
  output logic [CW-1:0] iss_cycles,
  output logic          iss_zext,
  output logic          iss_mark,
  output logic [RW-1:0] iss_dst
);
  localparam logic [1:0] CLS_OTHER = 2'd0;
  localparam logic [1:0] CLS_NOP   = 2'd1;
  localparam logic [1:0] CLS_XCHG  = 2'd2;

  logic [CW-1:0] occ;

  wire nop1    = op_b0 == 8'h90;
  wire xch_acc = (op_b0[7:3] == 5'b10010) && (op_b0[2:0] != 3'd0);
  wire xch_rr  = (op_b0 == 8'h87) && (op_b1[7:6] == 2'b11);
  wire xch     = xch_acc | xch_rr;
  wire mnop    = (op_b0 == 8'h0F) && (op_b1 == 8'h1F);
  wire writes  = !nop1 && !mnop;
  wire hazard  = busy_mask[src_reg] | busy_mask[dst_reg];

  wire [CW-1:0] cyc_sel = xch ? CW'(XCHG_CYCLES) : CW'(BASE_CYCLES);
  wire [1:0]    cls_sel = nop1 ? CLS_NOP : (xch ? CLS_XCHG : CLS_OTHER);

  assign in_ready = (occ == '0) && (nop1 || !hazard);
  wire fire = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ        <= '0;
      iss_valid  <= 1'b0;
      iss_cls    <= CLS_OTHER;
      iss_cycles <= '0;
      iss_zext   <= 1'b0;
      iss_mark   <= 1'b0;
      iss_dst    <= '0;
    end else begin
      iss_valid <= fire;
      if (fire)
        occ <= cyc_sel - CW'(1);
      else if (occ != '0)
        occ <= occ - CW'(1);
      if (fire) begin
        iss_cls    <= cls_sel;
        iss_cycles <= cyc_sel;
        iss_zext   <= mode64 && op32 && writes;
        iss_mark   <= writes;
        iss_dst    <= dst_reg;
      end
    end
  end
endmodule

// File: rtl/nop_issue_classifier_chk.sv
module nop_issue_classifier_chk #(
  parameter int NREG        = 16,
  parameter int XCHG_CYCLES = 3,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(XCHG_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    op_b0,
  input logic          mode64,
  input logic [RW-1:0] src_reg,
  input logic [RW-1:0] dst_reg,
  input logic [NREG-1:0] busy_mask,
  input logic          iss_valid,
  input logic [1:0]    iss_cls,
  input logic [CW-1:0] iss_cycles,
  input logic          iss_zext,
  input logic          iss_mark
);
  assert_nop_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == 2'd1) |-> (!iss_mark && !iss_zext && iss_cycles == CW'(1)));

  assert_xchg_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == 2'd2) |-> (iss_cycles == CW'(XCHG_CYCLES)));

  assert_xchg_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cycles == CW'(XCHG_CYCLES)) |-> !in_ready);

  assert_xchg_block2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cycles == CW'(XCHG_CYCLES)) |=> !in_ready);

  assert_hazard_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_b0 != 8'h90 && (busy_mask[src_reg] || busy_mask[dst_reg])) |-> !in_ready);

  assert_pulse_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !iss_valid);

  assert_legacy_no_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode64) |=> !iss_zext);
endmodule

bind nop_issue_classifier nop_issue_classifier_chk #(.NREG(NREG), .XCHG_CYCLES(XCHG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op_b0(op_b0),
  .mode64(mode64), .src_reg(src_reg), .dst_reg(dst_reg), .busy_mask(busy_mask),
  .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_cycles(iss_cycles),
  .iss_zext(iss_zext), .iss_mark(iss_mark)
);

// File: tb/nop_issue_classifier_bench.sv
module nop_issue_classifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] op_b0 = 8'h00, op_b1 = 8'h00;
  logic mode64 = 1'b0, op32 = 1'b0;
  logic [3:0] src_reg = 4'd0, dst_reg = 4'd0;
  logic [15:0] busy_mask = 16'h0;
  logic iss_valid, iss_zext, iss_mark;
  logic [1:0] iss_cls, iss_cycles;
  logic [3:0] iss_dst;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nop_issue_classifier u_nop_issue_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_b0(op_b0), .op_b1(op_b1), .mode64(mode64), .op32(op32),
    .src_reg(src_reg), .dst_reg(dst_reg), .busy_mask(busy_mask),
    .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_cycles(iss_cycles),
    .iss_zext(iss_zext), .iss_mark(iss_mark), .iss_dst(iss_dst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b0, input logic [7:0] b1, input logic m64,
                     input logic o32, input logic [3:0] s, input logic [3:0] d,
                     input logic [15:0] busy);
    op_b0 = b0; op_b1 = b1; mode64 = m64; op32 = o32;
    src_reg = s; dst_reg = d; busy_mask = busy; in_valid = 1'b1;
  endtask

  task automatic idle();
    in_valid = 1'b0; op_b0 = 8'h00; op_b1 = 8'h00; busy_mask = 16'h0;
  endtask

  task automatic t_reset();
    chk("R9", "in_ready after reset", in_ready, 1);
    chk("R9", "iss_valid after reset", iss_valid, 0);
  endtask

  task automatic t_nop_legacy();
    put(8'h90, 8'h00, 1'b0, 1'b1, 4'd0, 4'd0, 16'hFFFF);
    #1 chk("R3", "0x90 ready with all busy", in_ready, 1);
    step(); idle();
    chk("R1", "0x90 class", iss_cls, 1);
    chk("R1", "0x90 cycles", iss_cycles, 1);
    chk("R3", "0x90 mark", iss_mark, 0);
    chk("R8", "iss_valid pulse", iss_valid, 1);
    chk("R1", "ready after nop", in_ready, 1);
    step();
    chk("R8", "iss_valid idle", iss_valid, 0);
  endtask

  task automatic t_xchg_acc();
    put(8'h93, 8'h00, 1'b0, 1'b1, 4'd0, 4'd3, 16'h0);
    step(); idle();
    chk("R2", "0x93 class", iss_cls, 2);
    chk("R2", "0x93 cycles", iss_cycles, 3);
    chk("R7", "0x93 mark", iss_mark, 1);
    chk("R7", "0x93 dst", iss_dst, 3);
    chk("R2", "ready 1 after xchg", in_ready, 0);
    step();
    chk("R2", "ready 2 after xchg", in_ready, 0);
    step();
    chk("R2", "ready 3 after xchg", in_ready, 1);
  endtask

  task automatic t_multibyte_nop();
    put(8'h0F, 8'h1F, 1'b0, 1'b0, 4'd5, 4'd5, 16'h0020);
    #1 chk("R4", "0F1F held on busy", in_ready, 0);
    step();
    chk("R8", "no issue while held", iss_valid, 0);
    chk("R4", "0F1F still held", in_ready, 0);
    busy_mask = 16'h0;
    #1 chk("R4", "0F1F ready after clear", in_ready, 1);
    step(); idle();
    chk("R4", "0F1F issued", iss_valid, 1);
    chk("R5", "0F1F class", iss_cls, 0);
    chk("R5", "0F1F cycles", iss_cycles, 1);
    chk("R7", "0F1F mark", iss_mark, 0);
  endtask

  task automatic t_lea_hazard();
    put(8'h8D, 8'h40, 1'b1, 1'b1, 4'd2, 4'd7, 16'h0080);
    #1 chk("R4", "LEA held on dst busy", in_ready, 0);
    step();
    busy_mask = 16'h0;
    step(); idle();
    chk("R4", "LEA issued", iss_valid, 1);
    chk("R6", "LEA 64/32 zext", iss_zext, 1);
    chk("R7", "LEA dst", iss_dst, 7);
    chk("R5", "ready after LEA", in_ready, 1);
  endtask

  task automatic t_nop_64();
    put(8'h90, 8'h00, 1'b1, 1'b1, 4'd0, 4'd0, 16'h0001);
    #1 chk("R3", "64-bit 0x90 ready", in_ready, 1);
    step(); idle();
    chk("R1", "64-bit 0x90 class", iss_cls, 1);
    chk("R3", "64-bit 0x90 zext", iss_zext, 0);
    chk("R3", "64-bit 0x90 mark", iss_mark, 0);
  endtask

  task automatic t_xchg_rr_modes();
    put(8'h87, 8'hC0, 1'b1, 1'b1, 4'd0, 4'd0, 16'h0);
    step(); idle();
    chk("R2", "87C0 64 class", iss_cls, 2);
    chk("R6", "87C0 64 zext", iss_zext, 1);
    chk("R7", "87C0 64 mark", iss_mark, 1);
    step(); step();
    put(8'h87, 8'hC0, 1'b0, 1'b1, 4'd0, 4'd0, 16'h0);
    #1 chk("R2", "ready for legacy 87C0", in_ready, 1);
    step(); idle();
    chk("R2", "87C0 legacy class", iss_cls, 2);
    chk("R6", "87C0 legacy zext", iss_zext, 0);
    step(); step();
    put(8'h87, 8'h00, 1'b0, 1'b1, 4'd0, 4'd1, 16'h0);
    step(); idle();
    chk("R5", "87 memory form class", iss_cls, 0);
    chk("R5", "87 memory form ready", in_ready, 1);
  endtask

  task automatic t_other_sizes();
    put(8'h01, 8'hC8, 1'b1, 1'b0, 4'd1, 4'd2, 16'h0);
    step(); idle();
    chk("R6", "64-bit 16-op zext", iss_zext, 0);
    chk("R5", "other cycles", iss_cycles, 1);
    put(8'h01, 8'hC8, 1'b1, 1'b1, 4'd1, 4'd2, 16'h0);
    step();
    chk("R6", "64-bit 32-op zext", iss_zext, 1);
    put(8'h01, 8'hC8, 1'b1, 1'b1, 4'd1, 4'd2, 16'h0002);
    #1 chk("R4", "src busy held", in_ready, 0);
    idle();
    step();
    chk("R8", "no issue when idle", iss_valid, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop_legacy();
    t_xchg_acc();
    t_multibyte_nop();
    t_lea_hazard();
    t_nop_64();
    t_xchg_rr_modes();
    t_other_sizes();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule